// File: doc/BRIEF.md
# Single-Register Port Expander Serial Target

This block is the bus side of an eight-bit port expander that has exactly one register. A fast system clock oversamples the two wires of a Standard-mode I2C bus. The block finds START and STOP conditions, compares the seven-bit address with its own, and then acts on the direction bit. A write sends every data byte straight to the port. A read returns the live port value, byte after byte, for as long as the master keeps acknowledging.

There is no command byte and no pointer. The upper four address bits are fixed by a parameter that picks one of two prefixes, and three strap inputs give the lower three bits. The block pulls SDA low only through an open-drain enable. It never stretches the clock.

Top module: `i2c_port_target`

## Requirements
- R1: The address byte is sent MSB first. Its bits 7..4 are the prefix (4'b0100 when ALT_PREFIX is 0), bits 3..1 are strap[2:0], and bit 0 is the direction. When bits 7..1 match, `sda_oe` is high for the whole ninth SCL pulse after that byte.
- R2: After an address that does not match, the block never raises `sda_oe` and never pulses `wr_stb`, even for later bytes, until the next START.
- R3: In a write (direction bit 0), each data byte is taken MSB first and acknowledged in its ninth clock. When SCL falls at the end of that acknowledge clock, `wr_stb` pulses high for exactly one cycle and `wr_data` takes the byte.
- R4: A write may carry any number of data bytes. Each one produces its own strobe, and `wr_data` holds the last byte written.
- R5: In a read (direction bit 1), bytes are sent MSB first. Each byte is the value of `port_in` captured at the rising SCL edge of the acknowledge clock just before that byte.
- R6: While the master acknowledges, the block keeps sending bytes. After a master not-acknowledge, `sda_oe` stays low until the next START.
- R7: A repeated START after any byte restarts address reception, and a new direction takes effect.
- R8: A STOP returns the block to idle with `sda_oe` low.
- R9: `sda_oe` changes only while SCL is low. It never changes while SCL stays high.
- R10: During and after reset, `sda_oe` is 0, `wr_stb` is 0 and `wr_data` is 8'hFF.
- R11: With ALT_PREFIX set to 1, the prefix is 4'b0111, and addresses that use the other prefix are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Low three address bits |
| port_in | input | 8 | Live port pin levels, returned on reads |
| wr_stb | output | 1 | One-cycle pulse when an acknowledged data byte is written |
| wr_data | output | 8 | Last written port byte |

## Verification
A wrong bit count or a wrong state shows up on the bus within one byte. An acknowledge lands on the wrong clock, a read byte comes out shifted, or a strobe fires on a byte that was not acknowledged. The bench watches SDA at the middle of each SCL high period and counts the strobes. This ties every fault to the byte where it first appears. Because SDA is shared with a second instance that uses the other prefix, any release that is missed after a non-matching address or a not-acknowledge corrupts the next bit the master samples.

// File: rtl/i2c_port_target.sv
module i2c_port_target #(
  parameter bit ALT_PREFIX = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic [7:0] port_in,
  output logic       wr_stb,
  output logic [7:0] wr_data
);
  localparam logic [3:0] PREFIX = ALT_PREFIX ? 4'b0111 : 4'b0100;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WDAT, WACK, RDAT, RACK, SKIP} st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rw, mack;

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];

  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire hit      = (sh[7:1] == {PREFIX, strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '1;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= 8'hFF;
    end else begin
      wr_stb <= 1'b0;
      if (start) begin
        st     <= ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ADDR, WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == WDAT) begin
                sda_oe <= 1'b1;
                st     <= WACK;
              end else if (hit) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= AACK;
              end else begin
                st <= SKIP;
              end
            end
          end
          AACK: begin
            if (scl_rise) begin
              tx <= port_in;
            end else if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st     <= RDAT;
                sda_oe <= ~tx[7];
              end else begin
                st     <= WDAT;
                sda_oe <= 1'b0;
              end
            end
          end
          WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              wr_stb  <= 1'b1;
              wr_data <= sh;
              cnt     <= '0;
              st      <= WDAT;
            end
          end
          RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b1};
              end
            end
          end
          RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              tx   <= port_in;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                st     <= RDAT;
                sda_oe <= ~tx[7];
              end else begin
                st <= SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_port_target_chk.sv
module i2c_port_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_stb
);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R3
  strobe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sda_oe);

  // R9
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R9
  oe_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));
endmodule

bind i2c_port_target i2c_port_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wr_stb(wr_stb)
);

// File: tb/sim_i2c_port_target.sv
module sim_i2c_port_target;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] port_in = 8'hA5;
  logic oe0, oe1, stb0, stb1;
  logic [7:0] wd0, wd1;
  wire  sda = m_sda & ~oe0 & ~oe1;

  int n_chk = 0, n_bad = 0, cnt0 = 0, cnt1 = 0, viol = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #5 clk = ~clk;

  i2c_port_target #(.ALT_PREFIX(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl),
    .sda_i(sda), .sda_oe(oe0), .strap(3'b101), .port_in(port_in), .wr_stb(stb0), .wr_data(wd0));
  i2c_port_target #(.ALT_PREFIX(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl),
    .sda_i(sda), .sda_oe(oe1), .strap(3'b010), .port_in(port_in), .wr_stb(stb1), .wr_data(wd1));

  always @(negedge clk) begin
    if (stb0) cnt0++;
    if (stb1) cnt1++;
    if (rst_n && m_scl && prev_scl && (oe0 != prev_oe)) viol++;
    prev_scl = m_scl;
    prev_oe  = oe0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(~mack);
  endtask

  task automatic t_reset;
    chk("R10 sda_oe after reset", oe0, 1'b0);
    chk("R10 wr_stb after reset", stb0, 1'b0);
    chk("R10 wr_data after reset", wd0, 8'hFF);
  endtask

  task automatic t_write;
    logic ack;
    int c0 = cnt0, c1 = cnt1;
    bus_start;
    wbyte(8'h4A, ack); chk("R1 address acknowledged", ack, 1'b1);
    wbyte(8'h5A, ack); chk("R3 data byte acknowledged", ack, 1'b1);
    chk("R3 strobe after first byte", cnt0 - c0, 1);
    chk("R3 wr_data first byte", wd0, 8'h5A);
    wbyte(8'hC3, ack);
    wbyte(8'h00, ack); chk("R4 third byte acknowledged", ack, 1'b1);
    bus_stop;
    chk("R4 one strobe per byte", cnt0 - c0, 3);
    chk("R4 wr_data holds last byte", wd0, 8'h00);
    chk("R8 released after stop", oe0, 1'b0);
    chk("R11 other variant ignored this write", cnt1 - c1, 0);
  endtask

  task automatic t_badaddr;
    logic ack;
    int c0 = cnt0;
    bus_start;
    wbyte(8'h4C, ack); chk("R2 wrong address not acknowledged", ack, 1'b0);
    wbyte(8'h77, ack); chk("R2 later byte not acknowledged", ack, 1'b0);
    bus_stop;
    chk("R2 no strobe after wrong address", cnt0 - c0, 0);
    chk("R2 wr_data untouched", wd0, 8'h00);
  endtask

  task automatic t_read;
    logic ack;
    logic [7:0] b1, b2;
    port_in = 8'hA5;
    bus_start;
    wbyte(8'h4B, ack); chk("R1 read address acknowledged", ack, 1'b1);
    fork
      begin wq(16*Q); port_in = 8'h3C; end
      rbyte(b1, 1'b1);
    join
    chk("R5 first read byte", b1, 8'hA5);
    fork
      begin wq(16*Q); port_in = 8'h0F; end
      rbyte(b2, 1'b0);
    join
    chk("R5 second byte captured at master ack", b2, 8'h3C);
    chk("R6 released after not-acknowledge", oe0, 1'b0);
    wq(4*Q);
    chk("R6 still released before stop", oe0, 1'b0);
    bus_stop;
    chk("R8 idle after read stop", oe0, 1'b0);
  endtask

  task automatic t_rstart;
    logic ack;
    logic [7:0] b;
    int c0 = cnt0;
    port_in = 8'h96;
    bus_start;
    wbyte(8'h4A, ack);
    wbyte(8'h11, ack);
    chk("R7 write before repeated start", wd0, 8'h11);
    bus_start;
    wbyte(8'h4B, ack); chk("R7 address after repeated start", ack, 1'b1);
    rbyte(b, 1'b0);
    chk("R7 read after repeated start", b, 8'h96);
    bus_stop;
    chk("R7 one strobe in combined transfer", cnt0 - c0, 1);
  endtask

  task automatic t_alt;
    logic ack;
    int c0 = cnt0, c1 = cnt1;
    bus_start;
    wbyte(8'h74, ack); chk("R11 alternate prefix acknowledged", ack, 1'b1);
    wbyte(8'h99, ack);
    bus_stop;
    chk("R11 alternate instance written", wd1, 8'h99);
    chk("R11 alternate strobe count", cnt1 - c1, 1);
    chk("R11 default instance ignored", cnt0 - c0, 0);
  endtask

  initial begin
    wq(5);
    t_reset;
    rst_n = 1'b1;
    wq(10);
    t_reset;
    t_write;
    t_badaddr;
    t_read;
    t_rstart;
    t_alt;
    chk("R9 sda_oe steady while SCL high", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule